// File: doc/BRIEF.md
# Tri-State Bicolor Status LED Driver

This block drives a single three-level pin that feeds two LEDs connected in opposite polarity. Driving the pin high lights the green LED, driving it low lights the red LED, and releasing it (output enable low) leaves both dark. Timed pulse patterns allow one pin to show five different conditions. Active indications are always sent as 4 ms pulses separated by 4 ms high-impedance gaps. A slow 256 ms blink phase and a 93.75 ms colour alternation are layered on top of the pulses. All timing comes from a quarter-millisecond tick, which is derived from the parameterised system clock frequency.

Per-port status flags are mapped onto condition numbers 1 to 5. A two-bit mode, sampled once after reset, chooses that mapping. When more than one condition is active, the highest condition number wins. Events that are short by nature (link pulse, transmit packet, receive packet) are stretched so that each one stays visible for at least one full blink phase. A second pin uses the same timebase for a shared collision and FIFO-error indicator. That pin pulls low for a collision and drives high for a FIFO error, and it can show both at the same time.

Top module: `led_bicolor_drv`

## Requirements
- R1: While `rst_ni` is low, and afterwards while no status input is active, both output enables are low. A pin with its enable low also has its level held low.
- R2: Each driven interval on the port pin lasts exactly SLOT_Q quarter-ms ticks (4 ms). It is followed by at least one high-impedance slot of the same length. The tick period is CLK_HZ/4000 clock cycles.
- R3: Condition 1 is steady green: the pin is driven high in every pulse slot. Condition 3 is steady red: the pin is driven low in every pulse slot.
- R4: Condition 2 (green) and condition 4 (red) blink. Their pulse slots appear only during a 256 ms on phase, and a 256 ms phase with no pulses follows it.
- R5: Condition 5 alternates colour. The level driven in pulse slots changes between high and low every 375 ticks (93.75 ms).
- R6: `port_stat_i` bits are: bit 0 receive link pulse, bit 1 transmit packet, bit 2 reversed polarity, bit 3 receive packet, bit 4 partitioned. In mode 0 these bits drive conditions 1, 2, 3, 4 and 5 in that order.
- R7: In mode 1 only link pulse (condition 1) and receive packet (condition 4) are shown. Polarity, transmit and partition have no effect.
- R8: In mode 2, link pulse is condition 1, partitioned is condition 2 and receive packet is condition 4.
- R9: In mode 3, link pulse is condition 1, receive packet is condition 2 and partitioned is condition 3.
- R10: `mode_i` is sampled on the first clock edge after reset is released. Later changes to it have no effect until the next reset.
- R11: When several conditions are active, only the one with the highest number is shown.
- R12: A single-cycle pulse on link pulse, transmit packet, receive packet, `col_i` or `fifo_err_i` is held active for 2*BLINK_Q ticks (512 ms).
- R13: On the shared pin, a collision drives low during pulse slots and a FIFO error drives high during gap slots. When both are active, both colours appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mapping mode, sampled after reset |
| port_stat_i | input | 5 | Port status flags (link, tx, polarity, rx, partition) |
| col_i | input | 1 | Collision event |
| fifo_err_i | input | 1 | FIFO error event |
| port_led_o | output | 1 | Port pin level (1 green, 0 red) |
| port_led_oe_o | output | 1 | Port pin output enable |
| cf_led_o | output | 1 | Collision/FIFO pin level |
| cf_led_oe_o | output | 1 | Collision/FIFO pin output enable |

## Verification
The hardest behaviour to show from the ports is the event stretch. One input pulse, one cycle long, must produce a full blink period of red pulses and then go completely dark. A second hard point is the phase relationship of three independent counters, which the pins only show indirectly. The bench runs with a small clock frequency so that one tick is two cycles. It measures run lengths of driven and dark intervals and the spacing of colour changes over windows longer than one blink period. This turns the 4 ms, 256 ms and 93.75 ms rules into counts that can be checked exactly.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  localparam int ST_W    = 5;
  localparam int ST_LNK  = 0;
  localparam int ST_TX   = 1;
  localparam int ST_POL  = 2;
  localparam int ST_RX   = 3;
  localparam int ST_PART = 4;
  localparam int NCOND   = 5;
  localparam int unsigned QTICK_HZ = 4000;

  typedef enum logic [2:0] {
    COND_NONE      = 3'd0,
    COND_GRN       = 3'd1,
    COND_GRN_BLINK = 3'd2,
    COND_RED       = 3'd3,
    COND_RED_BLINK = 3'd4,
    COND_ALT       = 3'd5
  } cond_e;

  // bit k of the result is condition k+1
  function automatic logic [NCOND-1:0] map_conds(input logic [1:0] mode,
                                                 input logic [ST_W-1:0] st);
    logic [NCOND-1:0] c;
    c    = '0;
    c[0] = st[ST_LNK];
    unique case (mode)
      2'd0: begin
        c[1] = st[ST_TX];
        c[2] = st[ST_POL];
        c[3] = st[ST_RX];
        c[4] = st[ST_PART];
      end
      2'd1: c[3] = st[ST_RX];
      2'd2: begin
        c[1] = st[ST_PART];
        c[3] = st[ST_RX];
      end
      default: begin
        c[1] = st[ST_RX];
        c[2] = st[ST_PART];
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/led_phase_div.sv
module led_phase_div #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic phase_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_timebase.sv
module led_timebase import led_drv_pkg::*; #(
  parameter int unsigned CLK_HZ  = 20_000_000,
  parameter int unsigned SLOT_Q  = 16,
  parameter int unsigned BLINK_Q = 1024,
  parameter int unsigned ALT_Q   = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic qtick_o,
  output logic slot_on_o,
  output logic blink_on_o,
  output logic alt_grn_o
);
  localparam int unsigned DIV = (CLK_HZ / QTICK_HZ > 0) ? CLK_HZ / QTICK_HZ : 1;

  generate
    if (DIV == 1) begin : g_nodiv
      assign qtick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] DLAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             div_q <= '0;
        else if (div_q == DLAST) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign qtick_o = (div_q == DLAST);
    end
  endgenerate

  led_phase_div #(.PERIOD(SLOT_Q)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick_o), .phase_o(slot_on_o));

  led_phase_div #(.PERIOD(BLINK_Q)) u_blink (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick_o), .phase_o(blink_on_o));

  led_phase_div #(.PERIOD(ALT_Q)) u_alt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick_o), .phase_o(alt_grn_o));
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned HOLD = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ev_i,
  output logic act_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (ev_i)                   cnt_q <= CW'(HOLD);
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = ev_i | (cnt_q != '0);
endmodule

// File: rtl/led_bicolor_drv.sv
module led_bicolor_drv import led_drv_pkg::*; #(
  parameter int unsigned    CLK_HZ     = 20_000_000,
  parameter int unsigned    SLOT_Q     = 16,
  parameter int unsigned    BLINK_Q    = 1024,
  parameter int unsigned    ALT_Q      = 375,
  parameter logic [ST_W-1:0] EVENT_MASK = 5'b01011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [ST_W-1:0] port_stat_i,
  input  logic            col_i,
  input  logic            fifo_err_i,
  output logic            port_led_o,
  output logic            port_led_oe_o,
  output logic            cf_led_o,
  output logic            cf_led_oe_o
);
  localparam int unsigned HOLD_Q = 2 * BLINK_Q;

  logic qtick, slot_on, blink_on, alt_grn;

  led_timebase #(
    .CLK_HZ(CLK_HZ), .SLOT_Q(SLOT_Q), .BLINK_Q(BLINK_Q), .ALT_Q(ALT_Q)
  ) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .qtick_o(qtick),
    .slot_on_o(slot_on), .blink_on_o(blink_on), .alt_grn_o(alt_grn));

  // status conditioning
  logic [ST_W-1:0] stat_s;
  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_stat
      if (EVENT_MASK[i]) begin : g_ev
        led_stretch #(.HOLD(HOLD_Q)) u_st (
          .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick),
          .ev_i(port_stat_i[i]), .act_o(stat_s[i]));
      end else begin : g_lvl
        assign stat_s[i] = port_stat_i[i];
      end
    end
  endgenerate

  logic col_s, fifo_s;
  led_stretch #(.HOLD(HOLD_Q)) u_col_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick), .ev_i(col_i), .act_o(col_s));
  led_stretch #(.HOLD(HOLD_Q)) u_fifo_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(qtick), .ev_i(fifo_err_i), .act_o(fifo_s));

  // mode captured once after reset release
  logic [1:0] mode_q;
  logic       armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 2'd0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      mode_q  <= mode_i;
      armed_q <= 1'b1;
    end
  end

  logic [NCOND-1:0] cond_v, sel_oh;
  cond_e            win;

  assign cond_v = armed_q ? map_conds(mode_q, stat_s) : '0;

  // highest-numbered active condition wins
  always_comb begin
    sel_oh = '0;
    win    = COND_NONE;
    for (int k = NCOND - 1; k >= 0; k--) begin
      if (cond_v[k] && win == COND_NONE) begin
        sel_oh[k] = 1'b1;
        win       = cond_e'(3'(k + 1));
      end
    end
  end

  logic port_oe_d, port_lvl_d, cf_oe_d, cf_lvl_d;

  always_comb begin
    port_oe_d  = 1'b0;
    port_lvl_d = 1'b0;
    unique case (win)
      COND_GRN:       begin port_oe_d = slot_on;            port_lvl_d = 1'b1;    end
      COND_GRN_BLINK: begin port_oe_d = slot_on & blink_on; port_lvl_d = 1'b1;    end
      COND_RED:       begin port_oe_d = slot_on;            port_lvl_d = 1'b0;    end
      COND_RED_BLINK: begin port_oe_d = slot_on & blink_on; port_lvl_d = 1'b0;    end
      COND_ALT:       begin port_oe_d = slot_on;            port_lvl_d = alt_grn; end
      default:        ;
    endcase
    if (!port_oe_d) port_lvl_d = 1'b0;
  end

  // collision in pulse slots (low), FIFO error in gap slots (high)
  always_comb begin
    cf_oe_d  = 1'b0;
    cf_lvl_d = 1'b0;
    if (col_s && slot_on) begin
      cf_oe_d = 1'b1;
    end else if (fifo_s && !slot_on) begin
      cf_oe_d  = 1'b1;
      cf_lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_led_o    <= 1'b0;
      port_led_oe_o <= 1'b0;
      cf_led_o      <= 1'b0;
      cf_led_oe_o   <= 1'b0;
    end else begin
      port_led_o    <= port_lvl_d;
      port_led_oe_o <= port_oe_d;
      cf_led_o      <= cf_lvl_d;
      cf_led_oe_o   <= cf_oe_d;
    end
  end
endmodule

// File: rtl/led_bicolor_drv_chk.sv
module led_bicolor_drv_chk import led_drv_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ST_W-1:0]  port_stat_i,
  input logic [ST_W-1:0]  stat_s,
  input logic             slot_on,
  input logic [1:0]       mode_q,
  input logic             armed_q,
  input logic [NCOND-1:0] sel_oh,
  input logic             port_led_o,
  input logic             port_led_oe_o,
  input logic             cf_led_o,
  input logic             cf_led_oe_o
);
  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_led_oe_o |-> !port_led_o);

  // R2
  port_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_led_oe_o |-> $past(slot_on));

  // R13
  cf_col_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_led_oe_o && !cf_led_o) |-> $past(slot_on));

  // R13
  cf_fifo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_led_oe_o && cf_led_o) |-> !$past(slot_on));

  // R10
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(mode_q));

  // R11
  single_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh));

  // R12
  rx_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_stat_i[ST_RX]) |-> stat_s[ST_RX]);

  // R12
  lnk_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_stat_i[ST_LNK]) |-> stat_s[ST_LNK]);
endmodule

bind led_bicolor_drv led_bicolor_drv_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_stat_i(port_stat_i), .stat_s(stat_s),
  .slot_on(slot_on), .mode_q(mode_q), .armed_q(armed_q), .sel_oh(sel_oh),
  .port_led_o(port_led_o), .port_led_oe_o(port_led_oe_o),
  .cf_led_o(cf_led_o), .cf_led_oe_o(cf_led_oe_o));

// File: tb/led_bicolor_drv_bench.sv
module led_bicolor_drv_bench;
  // 8000 Hz => 2 cycles per quarter-ms tick
  localparam int SLOT_C = 32;
  localparam int DARK_C = 2048 + SLOT_C;
  localparam int ALT_C  = 750;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [4:0] stat = '0;
  logic       col = 1'b0, fifo = 1'b0;
  logic       p_lvl, p_oe, c_lvl, c_oe;

  led_bicolor_drv #(.CLK_HZ(8000)) u_led_bicolor_drv (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .port_stat_i(stat),
    .col_i(col), .fifo_err_i(fifo),
    .port_led_o(p_lvl), .port_led_oe_o(p_oe),
    .cf_led_o(c_lvl), .cf_led_oe_o(c_oe));

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;

  // monitor
  logic mon_clr = 1'b0, mon_en = 1'b0, mon_sel = 1'b0;
  int on_c, grn_c, red_c, run, off, max_run, max_off, last_col;
  int chg_cnt, chg_min, chg_max, last_chg, cyc;
  bit seen_on, seen_off;
  wire m_oe  = mon_sel ? c_oe : p_oe;
  wire m_lvl = mon_sel ? c_lvl : p_lvl;

  always @(negedge clk) begin
    if (mon_clr) begin
      on_c = 0; grn_c = 0; red_c = 0; run = 0; off = 0; max_run = 0; max_off = 0;
      last_col = -1; chg_cnt = 0; chg_min = 1000000; chg_max = 0; last_chg = 0;
      cyc = 0; seen_on = 0; seen_off = 0;
    end else if (mon_en) begin
      cyc++;
      if (m_oe) begin
        on_c++;
        if (m_lvl) grn_c++; else red_c++;
        if (off > 0 && seen_on && off > max_off) max_off = off;
        off = 0; run++; seen_on = 1;
        if (last_col >= 0 && int'(m_lvl) != last_col) begin
          if (chg_cnt > 0) begin
            if (cyc - last_chg < chg_min) chg_min = cyc - last_chg;
            if (cyc - last_chg > chg_max) chg_max = cyc - last_chg;
          end
          chg_cnt++; last_chg = cyc;
        end
        last_col = int'(m_lvl);
      end else begin
        if (run > 0 && seen_off && run > max_run) max_run = run;
        run = 0; off++; seen_off = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe(input int n, input bit sel);
    @(posedge clk); mon_sel = sel; mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0; mon_en = 1'b1;
    repeat (n) @(posedge clk);
    mon_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_ni = 1'b0; mode_i = m; stat = '0; col = 1'b0; fifo = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_steady(input bit green, input string req);
    observe(4200, 1'b0);
    chk(max_run == SLOT_C, req, "pulse length", max_run, SLOT_C);
    chk(max_off <= SLOT_C && max_off > 0, req, "gap length", max_off, SLOT_C);
    if (green) chk(grn_c > 2000 && red_c == 0, req, "green only", red_c, 0);
    else       chk(red_c > 2000 && grn_c == 0, req, "red only", grn_c, 0);
  endtask

  task automatic expect_blink(input bit green, input string req);
    observe(8400, 1'b0);
    chk(max_run == SLOT_C, req, "blink pulse length", max_run, SLOT_C);
    chk(max_off >= DARK_C - 4 && max_off <= DARK_C + 4, req, "dark phase", max_off, DARK_C);
    if (green) chk(grn_c > 0 && red_c == 0, req, "blink green only", red_c, 0);
    else       chk(red_c > 0 && grn_c == 0, req, "blink red only", grn_c, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_ni = 1'b0; stat = '1; col = 1'b1; fifo = 1'b1;
    repeat (3) @(negedge clk);
    chk(!p_oe && !c_oe && !p_lvl, "R1", "enables in reset", int'(p_oe) + int'(c_oe), 0);
    do_reset(2'd0);
    observe(300, 1'b0);
    chk(on_c == 0, "R1", "port idle", on_c, 0);
    observe(300, 1'b1);
    chk(on_c == 0, "R1", "cf idle", on_c, 0);
  endtask

  task automatic t_mode0();
    do_reset(2'd0); stat = 5'b00001; expect_steady(1'b1, "R3 R6 cond1");
    do_reset(2'd0); stat = 5'b00100; expect_steady(1'b0, "R3 R6 cond3");
    do_reset(2'd0); stat = 5'b00010; expect_blink(1'b1, "R4 R6 cond2");
    do_reset(2'd0); stat = 5'b01000; expect_blink(1'b0, "R4 R6 cond4");
    do_reset(2'd0); stat = 5'b10000;
    observe(4200, 1'b0);
    chk(grn_c > 0 && red_c > 0, "R5", "both colours", grn_c * red_c, 1);
    chk(chg_cnt >= 3, "R5", "colour changes", chg_cnt, 5);
    chk(chg_min >= ALT_C - 40 && chg_max <= ALT_C + 40, "R5", "alt interval", chg_max, ALT_C);
    chk(max_run == SLOT_C, "R2", "alt pulse length", max_run, SLOT_C);
  endtask

  task automatic t_priority();
    do_reset(2'd0); stat = 5'b00101;
    observe(1000, 1'b0);
    chk(red_c > 0 && grn_c == 0, "R11", "cond3 over cond1", grn_c, 0);
    do_reset(2'd0); stat = 5'b11111;
    observe(2000, 1'b0);
    chk(red_c > 0 && grn_c > 0 && chg_cnt >= 1, "R11", "cond5 over all", chg_cnt, 2);
  endtask

  task automatic t_stretch();
    do_reset(2'd0);
    @(negedge clk); stat[3] = 1'b1;
    @(negedge clk); stat[3] = 1'b0;
    observe(4300, 1'b0);
    chk(red_c >= 990 && grn_c == 0, "R12", "stretched red cycles", red_c, 1024);
    observe(500, 1'b0);
    chk(on_c == 0, "R12", "dark after hold", on_c, 0);
  endtask

  task automatic t_modes();
    do_reset(2'd1); stat = 5'b10110;
    observe(600, 1'b0);
    chk(on_c == 0, "R7", "ignored flags", on_c, 0);
    stat = 5'b11110;
    observe(1200, 1'b0);
    chk(red_c > 0 && grn_c == 0, "R7", "rx as cond4", grn_c, 0);
    do_reset(2'd2); stat = 5'b10000; expect_blink(1'b1, "R8 part cond2");
    do_reset(2'd3); stat = 5'b01000; expect_blink(1'b1, "R9 rx cond2");
    do_reset(2'd3); stat = 5'b10000; expect_steady(1'b0, "R9 part cond3");
  endtask

  task automatic t_latch();
    do_reset(2'd0);
    mode_i = 2'd1; stat = 5'b00100;
    observe(600, 1'b0);
    chk(red_c > 0, "R10", "mode 0 kept after change", red_c, 300);
  endtask

  task automatic t_cf();
    do_reset(2'd0); col = 1'b1;
    observe(600, 1'b1);
    chk(red_c > 0 && grn_c == 0, "R13", "collision low only", grn_c, 0);
    do_reset(2'd0); fifo = 1'b1;
    observe(600, 1'b1);
    chk(grn_c > 0 && red_c == 0, "R13", "fifo high only", red_c, 0);
    do_reset(2'd0); col = 1'b1; fifo = 1'b1;
    observe(600, 1'b1);
    chk(grn_c > 250 && red_c > 250, "R13", "both shown", grn_c + red_c, 600);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_priority();
    t_stretch();
    t_modes();
    t_latch();
    t_cf();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule